// File: doc/BRIEF.md
# Way-Partitioned Cache Tag Slice

This block holds the tags, valid bits and replacement state for one slice of a shared, inclusive last-level cache with 16 ways and 64-byte lines. Each request carries a line address and a class bit that says whether it comes from a CPU core or from the graphics engine. The slice compares the tag against every enabled way of the indexed set. It answers one cycle later with hit or miss and the way involved. On a miss it allocates the line into a victim way straight away.

Two masks limit where a fill may land. The first is a way-enable input that works in groups of four ways, like a fuse setting. The second is a 16-bit graphics allocation mask. Graphics fills may only use the ways set in that mask, and core fills may only use the ways cleared in it. Because of this split, a stream of graphics fills can never push out every core line. The cache is inclusive, so replacing a valid line raises a back-invalidate that carries the victim's full line address, letting the inner caches drop their copies.

Top module: `llc_tag_slice`

## Requirements
- R1: After synchronous reset every way of every set is invalid and every tree-LRU bit is 0. `rsp_valid` and `binv_valid` are low, and the first request to any address misses.
- R2: A request whose tag matches a valid line in an enabled way of its set hits, whatever its class. The response reports `rsp_hit`=1 and the matching way (the lowest one if several match). Address bits [5:0] have no effect on the result.
- R3: Way-enable bit g of `grp_en` enables ways 4g to 4g+3. A line held in a disabled way never hits, and a disabled way is never chosen for a fill.
- R4: A graphics request (`req_gfx`=1) allocates only into ways whose `gfx_mask` bit is 1. A core request (`req_gfx`=0) allocates only into ways whose `gfx_mask` bit is 0. Both are further limited to enabled ways.
- R5: On a miss, if any allowed way of the set is invalid, the lowest-numbered such way is filled and no back-invalidate is raised.
- R6: If every allowed way is valid, the victim comes from a 15-bit tree pseudo-LRU held per set. Node 1 is the root and node n has children 2n and 2n+1, where the left child covers the lower half of the ways. A node bit of 0 steers the search left and 1 steers it right, but the search always takes the half that contains an allowed way when only one half does. Every hit and every fill sets each node on the way's path so that it points away from that way.
- R7: A fill that replaces a valid line raises `binv_valid` in the same cycle as the response. `binv_line` then equals the victim's line address {old tag, set index}.
- R8: If a miss finds no allowed way, the response shows `rsp_err`=1, `rsp_hit`=0, `rsp_way`=0 and no back-invalidate. Tags, valid bits and LRU state are left unchanged.
- R9: Every accepted request produces exactly one response with `rsp_valid` high on the following cycle. A cycle without a request gives `rsp_valid` low on the next cycle.
- R10: Requests may be issued every cycle. A request sees all updates made by the request just before it, including one to the same set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_gfx | input | 1 | Requester class: 1 graphics, 0 core |
| req_addr | input | ADDR_W | Byte address of the request |
| grp_en | input | 4 | Way-enable, one bit per group of four ways |
| gfx_mask | input | 16 | Ways that graphics fills may use; core fills use the rest |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request hit |
| rsp_err | output | 1 | Fill refused because no allowed way exists |
| rsp_way | output | 4 | Way that hit or was filled |
| binv_valid | output | 1 | Back-invalidate for an evicted valid line |
| binv_line | output | ADDR_W-6 | Line address of the evicted line |

## Verification
A miss response and a back-invalidate can appear in the same cycle. This happens when the fill picks a victim that still holds a valid line, so the bench issues requests that fill a set completely within one requester's allowed ways and then sends one more miss. In that cycle it checks that the reported way matches the way the bench's own tree-LRU model picked, and that the back-invalidate address equals the tag that model recorded there. It also checks that the refused-fill case never raises a back-invalidate together with the error flag, even while the way-enable and allocation masks change at random between requests.

// File: rtl/llc_tag_pkg.sv
package llc_tag_pkg;

    localparam int WAYS   = 16;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int GRP_SZ = 4;
    localparam int GRPS   = WAYS / GRP_SZ;
    localparam int OFF_W  = 6;

    typedef logic [WAYS-1:0]  way_vec_t;
    typedef logic [WAY_W-1:0] way_idx_t;
    typedef logic [WAYS-1:0]  plru_t;

    typedef enum logic {
        CLS_CORE = 1'b0,
        CLS_GFX  = 1'b1
    } req_class_e;

    typedef struct packed {
        logic     hit;
        logic     err;
        way_idx_t way;
        logic     binv;
    } rsp_info_t;

    function automatic way_vec_t expand_groups(logic [GRPS-1:0] g);
        way_vec_t r;
        for (int i = 0; i < WAYS; i++) begin
            r[i] = g[i / GRP_SZ];
        end
        return r;
    endfunction

    function automatic way_idx_t first_set(way_vec_t v);
        way_idx_t r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (v[i]) r = i[WAY_W-1:0];
        end
        return r;
    endfunction

    function automatic plru_t plru_touch(plru_t t, way_idx_t w);
        plru_t           r;
        logic [WAY_W:0]  node;
        r    = t;
        node = 1;
        for (int lvl = WAY_W - 1; lvl >= 0; lvl--) begin
            r[node[WAY_W-1:0]] = ~w[lvl];
            node = {node[WAY_W-1:0], w[lvl]};
        end
        return r;
    endfunction

    function automatic way_idx_t plru_pick(plru_t t, way_vec_t allow);
        way_idx_t        way;
        logic [WAY_W:0]  node;
        logic            lok;
        logic            rok;
        logic            dir;
        way  = '0;
        node = 1;
        for (int lvl = WAY_W - 1; lvl >= 0; lvl--) begin
            lok = 1'b0;
            rok = 1'b0;
            for (int w = 0; w < WAYS; w++) begin
                if (allow[w] && ((w >> (lvl + 1)) == (int'(way) >> (lvl + 1)))) begin
                    if (w[lvl]) rok = 1'b1;
                    else        lok = 1'b1;
                end
            end
            dir      = (t[node[WAY_W-1:0]] && rok) || !lok;
            way[lvl] = dir;
            node     = {node[WAY_W-1:0], dir};
        end
        return way;
    endfunction

endpackage

// File: rtl/llc_tag_store.sv
module llc_tag_store
    import llc_tag_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
    output way_vec_t                    rd_valid,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  way_idx_t                    wr_way,
    input  logic [TAG_W-1:0]            wr_tag
);

    logic [TAG_W-1:0] tag_mem [SETS][WAYS];
    way_vec_t         vld_mem [SETS];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_tags[w] = tag_mem[rd_idx][w];
        end
        rd_valid = vld_mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_mem[s] <= '0;
            end
        end else if (wr_en) begin
            vld_mem[wr_idx][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx][wr_way] <= wr_tag;
        end
    end

endmodule

// File: rtl/llc_plru_store.sv
module llc_plru_store
    import llc_tag_pkg::*;
#(
    parameter int SETS = 64,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output plru_t            rd_tree,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  plru_t            upd_tree
);

    plru_t tree_mem [SETS];

    assign rd_tree = tree_mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                tree_mem[s] <= '0;
            end
        end else if (upd_en) begin
            tree_mem[upd_idx] <= upd_tree;
        end
    end

endmodule

// File: rtl/llc_victim_sel.sv
module llc_victim_sel
    import llc_tag_pkg::*;
(
    input  req_class_e cls,
    input  way_vec_t   gfx_mask,
    input  way_vec_t   en_ways,
    input  way_vec_t   valid,
    input  plru_t      tree,
    output logic       refuse,
    output way_idx_t   vway,
    output logic       victim_valid
);

    way_vec_t allow;
    way_vec_t free_ways;

    always_comb begin
        allow        = ((cls == CLS_GFX) ? gfx_mask : ~gfx_mask) & en_ways;
        free_ways    = allow & ~valid;
        refuse       = (allow == '0);
        vway         = (free_ways != '0) ? first_set(free_ways) : plru_pick(tree, allow);
        victim_valid = !refuse && valid[vway];
    end

endmodule

// File: rtl/llc_tag_slice.sv
module llc_tag_slice
    import llc_tag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 64,
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_gfx,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [GRPS-1:0]   grp_en,
    input  logic [WAYS-1:0]   gfx_mask,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              binv_valid,
    output logic [LINE_W-1:0] binv_line
);

    logic [IDX_W-1:0]           idx;
    logic [TAG_W-1:0]           tag;
    way_vec_t                   en_ways;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    way_vec_t                   set_valid;
    plru_t                      set_tree;
    plru_t                      next_tree;
    way_vec_t                   match;
    logic                       hit;
    way_idx_t                   hit_way;
    logic                       refuse;
    way_idx_t                   vway;
    logic                       victim_valid;
    way_idx_t                   acc_way;
    logic                       do_alloc;
    logic                       do_touch;
    req_class_e                 cls;
    rsp_info_t                  rsp_d;
    rsp_info_t                  rsp_q;
    logic                       rsp_vld_q;
    logic [LINE_W-1:0]          binv_d;
    logic [LINE_W-1:0]          binv_q;

    assign idx     = req_addr[OFF_W +: IDX_W];
    assign tag     = req_addr[ADDR_W-1 -: TAG_W];
    assign en_ways = expand_groups(grp_en);
    assign cls     = req_gfx ? CLS_GFX : CLS_CORE;

    llc_tag_store #(
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) i_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx),
        .rd_tags  (set_tags),
        .rd_valid (set_valid),
        .wr_en    (do_alloc),
        .wr_idx   (idx),
        .wr_way   (vway),
        .wr_tag   (tag)
    );

    llc_plru_store #(
        .SETS (SETS)
    ) i_plru (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx),
        .rd_tree  (set_tree),
        .upd_en   (do_touch),
        .upd_idx  (idx),
        .upd_tree (next_tree)
    );

    llc_victim_sel i_vsel (
        .cls          (cls),
        .gfx_mask     (gfx_mask),
        .en_ways      (en_ways),
        .valid        (set_valid),
        .tree         (set_tree),
        .refuse       (refuse),
        .vway         (vway),
        .victim_valid (victim_valid)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_valid[w] && en_ways[w] && (set_tags[w] == tag);
    end

    assign hit       = (match != '0);
    assign hit_way   = first_set(match);
    assign acc_way   = hit ? hit_way : vway;
    assign do_alloc  = req_valid && !hit && !refuse;
    assign do_touch  = req_valid && (hit || !refuse);
    assign next_tree = plru_touch(set_tree, acc_way);

    always_comb begin
        rsp_d.hit  = req_valid && hit;
        rsp_d.err  = req_valid && !hit && refuse;
        rsp_d.way  = do_touch ? acc_way : '0;
        rsp_d.binv = do_alloc && victim_valid;
        binv_d     = rsp_d.binv ? {set_tags[vway], idx} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld_q <= 1'b0;
            rsp_q     <= '0;
            binv_q    <= '0;
        end else begin
            rsp_vld_q <= req_valid;
            rsp_q     <= rsp_d;
            binv_q    <= binv_d;
        end
    end

    assign rsp_valid  = rsp_vld_q;
    assign rsp_hit    = rsp_q.hit;
    assign rsp_err    = rsp_q.err;
    assign rsp_way    = rsp_q.way;
    assign binv_valid = rsp_q.binv;
    assign binv_line  = binv_q;

endmodule

// File: rtl/llc_tag_slice_chk.sv
module llc_tag_slice_chk
    import llc_tag_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_gfx,
    input logic [GRPS-1:0]  grp_en,
    input logic [WAYS-1:0]  gfx_mask,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_err,
    input logic [WAY_W-1:0] rsp_way,
    input logic             binv_valid
);

    logic            gfx_q;
    logic [GRPS-1:0] grp_q;
    logic [WAYS-1:0] mask_q;
    logic            fill_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            gfx_q  <= 1'b0;
            grp_q  <= '1;
            mask_q <= '0;
        end else begin
            gfx_q  <= req_gfx;
            grp_q  <= grp_en;
            mask_q <= gfx_mask;
        end
    end

    assign fill_now = rsp_valid && !rsp_hit && !rsp_err;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                        // R9
    AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);                                      // R9
    AST_BINV_ONLY_ON_FILL: assert property (@(posedge clk) disable iff (rst)
        binv_valid |-> fill_now);                                        // R7
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && !rsp_hit && !binv_valid && rsp_way == '0)); // R8
    AST_WAY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> grp_q[rsp_way[WAY_W-1:2]]);          // R3
    AST_GFX_FILL_IN_MASK: assert property (@(posedge clk) disable iff (rst)
        (fill_now && gfx_q) |-> mask_q[rsp_way]);                        // R4
    AST_CORE_FILL_OUT_MASK: assert property (@(posedge clk) disable iff (rst)
        (fill_now && !gfx_q) |-> !mask_q[rsp_way]);                      // R4

endmodule

bind llc_tag_slice llc_tag_slice_chk i_chk (.*);

// File: tb/test_llc_tag_slice.sv
`timescale 1ns/1ps
module test_llc_tag_slice;

    localparam int ADDR_W = 32;
    localparam int SETS   = 64;
    localparam int IDX_W  = 6;
    localparam int TAG_W  = ADDR_W - IDX_W - 6;
    localparam int LINE_W = ADDR_W - 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_gfx = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        grp_en = 4'hF;
    logic [15:0]       gfx_mask = 16'hF000;
    logic              rsp_valid;
    logic              rsp_hit;
    logic              rsp_err;
    logic [3:0]        rsp_way;
    logic              binv_valid;
    logic [LINE_W-1:0] binv_line;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    logic [TAG_W-1:0] m_tag  [SETS][16];
    bit               m_vld  [SETS][16];
    bit   [15:0]      m_tree [SETS];

    always #2.5 clk = ~clk;

    llc_tag_slice #(.ADDR_W(ADDR_W), .SETS(SETS)) i_llc_tag_slice (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_gfx(req_gfx),
        .req_addr(req_addr), .grp_en(grp_en), .gfx_mask(gfx_mask),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
        .rsp_way(rsp_way), .binv_valid(binv_valid), .binv_line(binv_line)
    );

    function automatic bit [15:0] ways_on(bit [3:0] g);
        bit [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = g[i >> 2];
        return r;
    endfunction

    function automatic bit any_in(bit [15:0] al, int lo, int n);
        for (int i = lo; i < lo + n; i++) if (al[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int tree_victim(bit [15:0] tr, bit [15:0] al);
        int lo = 0;
        int size = 16;
        int node = 1;
        while (size > 1) begin
            int half = size / 2;
            bit lok = any_in(al, lo, half);
            bit rok = any_in(al, lo + half, half);
            if ((tr[node] && rok) || !lok) begin
                lo = lo + half;
                node = 2 * node + 1;
            end else begin
                node = 2 * node;
            end
            size = half;
        end
        return lo;
    endfunction

    function automatic bit [15:0] tree_mark(bit [15:0] tr, int w);
        int lo = 0;
        int size = 16;
        int node = 1;
        while (size > 1) begin
            int half = size / 2;
            if (w >= lo + half) begin
                tr[node] = 1'b0;
                lo = lo + half;
                node = 2 * node + 1;
            end else begin
                tr[node] = 1'b1;
                node = 2 * node;
            end
            size = half;
        end
        return tr;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge, model it, compare one cycle later.
    task automatic issue(input bit gfx, input logic [TAG_W-1:0] t, input int ix,
                         input logic [5:0] off, input string force_req);
        bit [15:0]   en;
        bit [15:0]   allow;
        int          hw;
        int          fw;
        int          v;
        bit          e_hit;
        bit          e_err;
        bit          e_binv;
        int          e_way;
        logic [LINE_W-1:0] e_line;
        string       rq;
        logic [63:0] act;
        logic [63:0] exp;
        en = ways_on(grp_en);
        hw = -1;
        for (int w = 15; w >= 0; w--)
            if (m_vld[ix][w] && en[w] && m_tag[ix][w] == t) hw = w;
        e_hit = 0; e_err = 0; e_binv = 0; e_way = 0; e_line = '0;
        if (hw >= 0) begin
            e_hit = 1; e_way = hw; rq = "R2";
            m_tree[ix] = tree_mark(m_tree[ix], hw);
        end else begin
            allow = (gfx ? gfx_mask : ~gfx_mask) & en;
            if (allow == 0) begin
                e_err = 1; rq = "R8";
            end else begin
                fw = -1;
                for (int w = 15; w >= 0; w--)
                    if (allow[w] && !m_vld[ix][w]) fw = w;
                if (fw >= 0) begin
                    v = fw; rq = "R5";
                end else begin
                    v = tree_victim(m_tree[ix], allow); rq = "R6";
                end
                if (m_vld[ix][v]) begin
                    e_binv = 1; e_line = {m_tag[ix][v], ix[IDX_W-1:0]}; rq = "R7";
                end
                e_way = v;
                m_tag[ix][v] = t;
                m_vld[ix][v] = 1;
                m_tree[ix] = tree_mark(m_tree[ix], v);
            end
        end
        if (force_req != "") rq = force_req;
        req_valid = 1;
        req_gfx   = gfx;
        req_addr  = {t, ix[IDX_W-1:0], off};
        @(negedge clk);
        act = {rsp_valid, rsp_hit, rsp_err, binv_valid, rsp_way, 4'h0, 24'h0, binv_line};
        exp = {1'b1, e_hit, e_err, e_binv, e_way[3:0], 4'h0, 24'h0, e_line};
        check(act == exp, rq, "response", act, exp);
    endtask

    task automatic idle(input string rq);
        req_valid = 0;
        @(negedge clk);
        check(!rsp_valid && !binv_valid, rq, "idle response",
              {62'h0, rsp_valid, binv_valid}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < SETS; s++) begin
            m_tree[s] = '0;
            for (int w = 0; w < 16; w++) begin
                m_vld[s][w] = 0;
                m_tag[s][w] = '0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!rsp_valid && !binv_valid && !rsp_hit, "R1", "reset outputs",
              {61'h0, rsp_valid, binv_valid, rsp_hit}, 64'h0);

        // first request after reset misses into way 0
        issue(0, 20'h00ABC, 3, 6'h00, "R1");
        // same line, other offset, other class: hit (R2), back to back (R10)
        issue(1, 20'h00ABC, 3, 6'h3F, "R10");
        issue(0, 20'h00ABC, 3, 6'h15, "R2");
        idle("R9");

        // fill set 5 across the core ways, then force tree-LRU evictions
        for (int k = 0; k < 12; k++) issue(0, 20'h100 + k, 5, 6'h0, "R5");
        issue(0, 20'h10C, 5, 6'h0, "R7");
        issue(0, 20'h10D, 5, 6'h0, "R6");
        // graphics fill confined to ways 12..15
        issue(1, 20'h200, 5, 6'h0, "R4");
        issue(1, 20'h201, 5, 6'h0, "R4");

        // no enabled way: refused, state must be intact afterwards
        grp_en = 4'h0;
        issue(1, 20'h300, 5, 6'h0, "R8");
        issue(0, 20'h301, 5, 6'h0, "R8");
        grp_en = 4'hF;
        issue(1, 20'h200, 5, 6'h0, "R8");

        // disable group 0: line in way 0 of set 3 must miss and land elsewhere
        grp_en = 4'hE;
        issue(0, 20'h00ABC, 3, 6'h0, "R3");
        issue(0, 20'h00ABD, 3, 6'h0, "R3");
        grp_en = 4'hF;

        // graphics with empty allocation mask
        gfx_mask = 16'h0000;
        issue(1, 20'h400, 7, 6'h0, "R8");
        issue(0, 20'h400, 7, 6'h0, "R4");
        gfx_mask = 16'hF000;
        idle("R9");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            int  sel = $urandom_range(0, 9);
            int  ixs [4] = '{0, 1, 2, 63};
            bit [3:0]  ge [6] = '{4'hF, 4'hF, 4'hF, 4'hE, 4'h7, 4'hB};
            bit [15:0] gm [5] = '{16'hF000, 16'hFF00, 16'h000F, 16'h8001, 16'hF000};
            if (sel == 0) grp_en = ge[$urandom_range(0, 5)];
            if (sel == 1) gfx_mask = gm[$urandom_range(0, 4)];
            if (sel == 2) idle("R9");
            else issue($urandom_range(0, 1), 20'(32'h500 + $urandom_range(0, 39)),
                       ixs[$urandom_range(0, 3)], 6'($urandom_range(0, 63)), "");
        end
        idle("R9");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule